// File: doc/BRIEF.md
# AC Bias Reversal Event Counter

This block watches the AC bias line of a display panel and raises a status event once the line has reversed a programmed number of times. Rising and falling edges both count as reversals. Software programs a reversal count. A count of zero turns the function off. Software acknowledges each event with a clear strobe. The event request cannot be masked, so it goes straight to the interrupt logic.

Each time the programmed number of reversals is reached, the counter reloads from the programmed count at once. It then stays frozen until software acknowledges the event. While it is frozen, bias reversals are ignored. Once the flag is cleared, counting starts again from a full programmed count, so no acknowledged period is ever shortened or counted twice. The bias pin is taken to be synchronous to the block clock.

Top module: `acb_event_counter`

## Requirements
- R1: While `trip_cnt_i` is zero the function is disabled: reversals are not counted and `done_o` never rises.
- R2: A reversal is a cycle in which `bias_i` differs from its value sampled on the previous clock (sampled value resets to 0). Rising and falling reversals each decrement the counter by one while counting.
- R3: `done_o` rises on the clock edge that samples the reversal bringing the count to zero, which is the `trip_cnt_i`-th counted reversal since counting began or resumed.
- R4: On that edge the counter reloads from the value of `trip_cnt_i` present then. A change of `trip_cnt_i` during counting does not alter the count already in progress.
- R5: `done_o` is 0 after reset and stays high until `done_clr_i` is asserted. A clear while `done_o` is low has no effect.
- R6: While `done_o` is high the counter is frozen and reversals are ignored, including a reversal in the clear cycle. After the clear, a full `trip_cnt_i` reversals are needed for the next event.
- R7: When `trip_cnt_i` goes from zero to nonzero, the counter loads it on that edge and a reversal in that same cycle is not counted.
- R8: `done_o` falls on the clock edge that samples `done_clr_i` high while `done_o` is high.
- R9: Setting `trip_cnt_i` to zero while `done_o` is high keeps `done_o` high. On re-enabling before a clear, the counter stays frozen until the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bias_i | input | 1 | AC bias pin level, synchronous |
| trip_cnt_i | input | CNT_W | Reversals per event; zero disables |
| done_clr_i | input | 1 | Acknowledge strobe that clears the done flag |
| done_o | output | 1 | Count-done event request (not maskable) |

## Verification
The bound checker checks on every cycle the step-by-one decrement, the reload value at the moment the flag rises, the stickiness and clearing of the flag, the frozen counter while the flag is high, and the forced idle state when the count is zero. Only the bench scenarios can show the end-to-end reversal totals. These include the exact reversal on which the flag rises after enabling or after a clear, the reversal that is ignored in a clear cycle, a mid-count change of the programmed value taking effect only at the next event, and disabling and re-enabling while an event is still unacknowledged.

// File: rtl/acb_pkg.sv
package acb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } acb_state_e;
endpackage

// File: rtl/acb_rev_detect.sv
module acb_rev_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rev_o
);
  logic pin_q;
  logic pin_d;

  always_comb begin
    pin_d = pin_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  // any level change against the previous sample is one reversal
  assign rev_o = pin_i ^ pin_q;
endmodule

// File: rtl/acb_rev_counter.sv
module acb_rev_counter
  import acb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rev_i,
  input  logic [CNT_W-1:0] trip_i,
  input  logic             clr_i,
  output logic             done_o,
  output acb_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntOne  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CntZero = '0;

  acb_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en, st_en, done_en;
  logic             enabled;

  assign enabled = (trip_i != CntZero);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (clr_i) begin
      done_d = 1'b0;
    end
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = trip_i;
        if (enabled) begin
          st_d = (done_q && !clr_i) ? ST_HOLD : ST_RUN;
        end
      end
      ST_RUN: begin
        if (!enabled) begin
          st_d = ST_IDLE;
        end else if (rev_i) begin
          if (cnt_q <= CntOne) begin
            done_d = 1'b1;
            cnt_d  = trip_i;
            st_d   = ST_HOLD;
          end else begin
            cnt_d = cnt_q - CntOne;
          end
        end
      end
      ST_HOLD: begin
        if (!enabled) begin
          st_d = ST_IDLE;
        end else if (clr_i) begin
          st_d = ST_RUN;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  assign cnt_en  = (cnt_d != cnt_q);
  assign st_en   = (st_d != st_q);
  assign done_en = (done_d != done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (done_en) done_q <= done_d;
    end
  end

  assign done_o  = done_q;
  assign state_o = st_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/acb_event_counter.sv
module acb_event_counter
  import acb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bias_i,
  input  logic [CNT_W-1:0] trip_cnt_i,
  input  logic             done_clr_i,
  output logic             done_o
);
  logic             rev;
  acb_state_e       state;
  logic [CNT_W-1:0] cnt;

  acb_rev_detect u_rev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (bias_i),
    .rev_o  (rev)
  );

  acb_rev_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rev_i   (rev),
    .trip_i  (trip_cnt_i),
    .clr_i   (done_clr_i),
    .done_o  (done_o),
    .state_o (state),
    .cnt_o   (cnt)
  );
endmodule

// File: rtl/acb_event_counter_chk.sv
module acb_event_counter_chk
  import acb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] trip_cnt_i,
  input logic             done_clr_i,
  input logic             done_o,
  input logic             rev,
  input acb_state_e       state,
  input logic [CNT_W-1:0] cnt
);
  // R1
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_cnt_i == '0) |=> (state == ST_IDLE));

  // R2
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RUN && rev && trip_cnt_i != '0 && cnt > CNT_W'(1))
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R3
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(rev) && $past(trip_cnt_i) != '0));

  // R4
  reload_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cnt == $past(trip_cnt_i)));

  // R5
  sticky_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_clr_i) |=> done_o);

  // R6
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HOLD && trip_cnt_i != '0) |=> $stable(cnt));

  // R6
  hold_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HOLD) |-> done_o);

  // R8
  clear_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_clr_i) |=> !done_o);
endmodule

bind acb_event_counter acb_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trip_cnt_i (trip_cnt_i),
  .done_clr_i (done_clr_i),
  .done_o     (done_o),
  .rev        (rev),
  .state      (state),
  .cnt        (cnt)
);

// File: tb/acb_event_counter_tb.sv
module acb_event_counter_tb;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         bias;
  logic [W-1:0] trip;
  logic         clr;
  logic         done;

  int n_chk;
  int n_fail;
  bit finished;

  // reference model state: 0 idle, 1 counting, 2 frozen
  int           m_st;
  int           m_cnt;
  logic         m_bq;
  logic         m_done;

  acb_event_counter #(.CNT_W(W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bias_i     (bias),
    .trip_cnt_i (trip),
    .done_clr_i (clr),
    .done_o     (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: done_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // expected behaviour per requirement, advanced once per clock
  function automatic void model(input logic b, input logic [W-1:0] t, input logic c);
    logic r;
    logic nd;
    r  = (b != m_bq);
    m_bq = b;
    nd = m_done;
    if (c) nd = 1'b0;
    case (m_st)
      0: begin
        m_cnt = int'(t);
        if (t != 0) m_st = (m_done && !c) ? 2 : 1;
      end
      1: begin
        if (t == 0) m_st = 0;
        else if (r) begin
          if (m_cnt <= 1) begin
            nd = 1'b1; m_cnt = int'(t); m_st = 2;
          end else m_cnt = m_cnt - 1;
        end
      end
      default: begin
        if (t == 0) m_st = 0;
        else if (c) m_st = 1;
      end
    endcase
    m_done = nd;
  endfunction

  task automatic step(input string req, input logic b, input logic [W-1:0] t, input logic c);
    bias = b; trip = t; clr = c;
    model(b, t, c);
    @(posedge clk);
    @(negedge clk);
    check(req, done, m_done);
  endtask

  task automatic toggle(input string req, input logic [W-1:0] t, input logic c);
    step(req, ~bias, t, c);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, done_o=%b expected end of test", done);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    n_chk = 0; n_fail = 0; finished = 0;
    bias = 0; trip = 0; clr = 0;
    m_st = 0; m_cnt = 0; m_bq = 0; m_done = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R5 reset", done, 1'b0);

    // R1: disabled, reversals ignored
    for (int i = 0; i < 6; i++) toggle("R1", 0, 0);
    check("R1 no event", done, 1'b0);

    // R7: enable with a reversal in the load cycle (not counted)
    toggle("R7", 3, 0);
    toggle("R2", 3, 0);   // rise or fall both count
    toggle("R2", 3, 0);
    check("R3 not yet", done, 1'b0);
    toggle("R3", 3, 0);
    check("R3 third reversal", done, 1'b1);

    // R6: frozen while flag high
    for (int i = 0; i < 4; i++) toggle("R6", 3, 0);
    check("R6 still set", done, 1'b1);

    // R8: clear with a reversal in the same cycle (ignored)
    toggle("R8", 3, 1);
    check("R8 cleared", done, 1'b0);
    toggle("R6", 3, 0);
    toggle("R6", 3, 0);
    check("R6 full count needed", done, 1'b0);
    toggle("R6", 3, 0);
    check("R6 event after full count", done, 1'b1);

    // R5: clear when low is harmless; R4 mid-count change
    step("R8", bias, 3, 1);
    step("R5", bias, 3, 1);
    toggle("R4", 3, 0);
    toggle("R4", 5, 0);   // new value, count in progress unchanged
    toggle("R4", 5, 0);
    check("R4 old count completes", done, 1'b1);
    step("R8", bias, 5, 1);
    for (int i = 0; i < 4; i++) toggle("R4", 5, 0);
    check("R4 reload used new value", done, 1'b0);
    toggle("R4", 5, 0);
    check("R4 fifth reversal", done, 1'b1);

    // R9: disable while set, re-enable before clear
    step("R9", bias, 0, 0);
    toggle("R9", 0, 0);
    check("R9 held while disabled", done, 1'b1);
    step("R9", bias, 2, 0);
    toggle("R9", 2, 0);
    toggle("R9", 2, 0);
    check("R9 frozen after re-enable", done, 1'b1);
    step("R9", bias, 2, 1);
    toggle("R9", 2, 0);
    toggle("R9", 2, 0);
    check("R9 counts after clear", done, 1'b1);

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic         rb;
      logic [W-1:0] rt;
      logic         rc;
      rb = ($urandom_range(0, 2) == 0) ? bias : ~bias;
      rt = ($urandom_range(0, 15) == 0) ? '0 : W'($urandom_range(1, 6));
      if (i % 40 > 3 && i % 40 < 35) rt = W'(3 + (i / 40) % 3);
      rc = ($urandom_range(0, 5) == 0);
      step("R3 random", rb, rt, rc);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule